// File: doc/BRIEF.md
# Synchronous Serial Port with Selectable Frame Sync

This block is a full-duplex synchronous serial port. It runs entirely on the external serial bit clock. Each direction has a one-word holding buffer in front of a shift register. Words move most significant bit first, one bit per clock. A transmit word begins only after a transmit start strobe. A receive word begins only after a separate receive start strobe.

A seven-bit control register sets the port's behaviour. It holds per-path enables, per-path interrupt enables, a word-length select, a sync mode and a transmit-sync source select. The transmit strobe is either accepted from outside or produced by the port and driven out on its own pin. In continuous mode a single strobe opens a stream, and later words follow with no gap. In interval mode every word waits for its own strobe.

The interrupt outputs tell the host when the transmit buffer can take a word and when a received word is waiting.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x0000, both interrupt outputs are low, the serial data output is low and the transmit-sync output enable is low.
- R2: Control bits 15..7 always read 0 and writes to them have no effect. Bit 0 is receive enable, bit 1 transmit enable, bit 2 receive interrupt enable, bit 3 transmit interrupt enable, bit 4 word length, bit 5 sync mode and bit 6 transmit-sync source.
- R3: While bit 0 or bit 1 currently reads 1, a write leaves bits 6..4 unchanged but still updates bits 3..0.
- R4: With bit 6 = 0, a strobe on the transmit-sync input sampled at a clock edge, with a word buffered, starts that word. Its MSB appears on the data output after that edge, and each following edge moves out one more bit.
- R5: Bit 4 = 0 selects 8-bit words (the buffered value's low byte), and bit 4 = 1 selects 16-bit words, in both directions.
- R6: With bit 6 = 1, the transmit-sync output enable is high, and the port drives a one-clock transmit-sync pulse while the transmit path is enabled, idle and holding a buffered word. The word starts at the edge that ends the pulse.
- R7: With bit 5 = 0 (continuous), a word buffered before the current word ends follows it with no gap and no new strobe, on both paths.
- R8: With bit 5 = 1 (interval), each word needs its own strobe. Without one, the next buffered word stays held and the data output stays low.
- R9: The receive path samples the data input on the edges after its strobe. After the last bit, the word is in the receive buffer. The receive interrupt is high while the buffer holds a word and bits 2 and 0 are set, and a buffer read clears it.
- R10: The transmit interrupt is high exactly while the transmit buffer is empty and bits 3 and 1 are set.
- R11: Clearing a path's enable abandons its word in progress and returns it to idle. After re-enabling, nothing moves until a fresh strobe arrives.
- R12: Bit 6 has no effect on the receive path, which always starts from the receive-sync input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write value |
| reg_rdata | output | 16 | Control register read value |
| txb_we | input | 1 | Load the transmit holding buffer |
| txb_wdata | input | 16 | Word to transmit (low byte in 8-bit mode) |
| rxb_re | input | 1 | Receive buffer read; empties the buffer |
| rxb_rdata | output | 16 | Last received word, zero-extended |
| ser_txd | output | 1 | Serial data out |
| ser_rxd | input | 1 | Serial data in |
| txs_in | input | 1 | External transmit start strobe |
| txs_out | output | 1 | Internally generated transmit start pulse |
| txs_oe | output | 1 | Output enable for the transmit-sync pin |
| rxs_in | input | 1 | Receive start strobe |
| irq_tx | output | 1 | Transmit buffer empty request |
| irq_rx | output | 1 | Receive buffer full request |

## Verification
The bench drives inputs just after a falling edge and samples just before the next falling edge. A register write or buffer load is therefore visible at the next sample, one edge later. A strobe driven in one sample period gives the MSB on the data output at the following sample. Bit n of a W-bit word appears n samples after that. The received word and its interrupt appear W samples after the strobe's end.

In continuous mode the second word's MSB is due at the same sample that first shows the first received word. The checks read every output at exactly these sample points and compare them with values worked out from the requirements.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int unsigned SIO_REG_W  = 16;
    localparam int unsigned SIO_DATA_W = 16;
    localparam int unsigned SIO_SHORT_W = 8;

    // control field positions, fixed because software decodes them
    localparam int unsigned POS_RX_EN   = 0;
    localparam int unsigned POS_TX_EN   = 1;
    localparam int unsigned POS_RX_IE   = 2;
    localparam int unsigned POS_TX_IE   = 3;
    localparam int unsigned POS_LONG    = 4;
    localparam int unsigned POS_INTV    = 5;
    localparam int unsigned POS_INT_SYN = 6;

    typedef struct packed {
        logic int_syn;  // 1: transmit sync generated and driven out
        logic intv;     // 1: sync before every word
        logic long_w;   // 1: 16-bit words
        logic tx_ie;
        logic rx_ie;
        logic tx_en;
        logic rx_en;
    } sio_ctrl_t;
endpackage

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
    import sio_pkg::*;
#(
    parameter int unsigned REG_W = SIO_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [6:0]       wdata,
    output sio_ctrl_t        ctrl,
    output logic [REG_W-1:0] rdata
);
    sio_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            ctrl_d.rx_en = wdata[POS_RX_EN];
            ctrl_d.tx_en = wdata[POS_TX_EN];
            ctrl_d.rx_ie = wdata[POS_RX_IE];
            ctrl_d.tx_ie = wdata[POS_TX_IE];
            // mode field only writable with both paths stopped
            if (!(ctrl_q.tx_en || ctrl_q.rx_en)) begin
                ctrl_d.long_w  = wdata[POS_LONG];
                ctrl_d.intv    = wdata[POS_INTV];
                ctrl_d.int_syn = wdata[POS_INT_SYN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl  = ctrl_q;
    assign rdata = REG_W'(ctrl_q);
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              int_syn,
    input  logic              intv,
    input  logic              long_w,
    input  logic              buf_we,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              txd,
    output logic              buf_full
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
    localparam int unsigned ALIGN = DATA_W - SHORT_W;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic [DATA_W-1:0] hold;
        logic              full;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic              sync_sel;
    logic              sync_gen;
    logic [DATA_W-1:0] aligned;
    logic [CNT_W-1:0]  first_cnt;

    always_comb begin
        st_d      = st_q;
        sync_gen  = int_syn && en && st_q.full && !st_q.busy;
        sync_sel  = int_syn ? sync_gen : sync_in;
        aligned   = long_w ? st_q.hold : (st_q.hold << ALIGN);
        first_cnt = long_w ? LAST_LONG : LAST_SHORT;

        if (!en) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                if (!intv && st_q.full) begin
                    st_d.shreg = aligned;
                    st_d.cnt   = first_cnt;
                    st_d.full  = 1'b0;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.shreg = st_q.shreg << 1;
                st_d.cnt   = st_q.cnt - 1'b1;
            end
        end else if (sync_sel && st_q.full) begin
            st_d.busy  = 1'b1;
            st_d.shreg = aligned;
            st_d.cnt   = first_cnt;
            st_d.full  = 1'b0;
        end

        if (buf_we) begin
            st_d.hold = buf_wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = sync_gen;
    assign txd      = st_q.busy && st_q.shreg[DATA_W-1];
    assign buf_full = st_q.full;
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              intv,
    input  logic              long_w,
    input  logic              sync_in,
    input  logic              rxd,
    input  logic              buf_re,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              buf_full
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
    localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic [DATA_W-1:0] hold;
        logic              full;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [DATA_W-1:0] next_sh;
    logic [CNT_W-1:0]  first_cnt;

    always_comb begin
        st_d      = st_q;
        next_sh   = {st_q.shreg[DATA_W-2:0], rxd};
        first_cnt = long_w ? LAST_LONG : LAST_SHORT;

        if (buf_re) st_d.full = 1'b0;

        if (!en) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.shreg = next_sh;
            if (st_q.cnt == '0) begin
                st_d.hold = long_w ? next_sh : (next_sh & SHORT_MASK);
                st_d.full = 1'b1;
                if (intv) st_d.busy = 1'b0;
                else      st_d.cnt  = first_cnt;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (sync_in) begin
            st_d.busy = 1'b1;
            st_d.cnt  = first_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_rdata = st_q.hold;
    assign buf_full  = st_q.full;
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int unsigned REG_W   = SIO_REG_W,
    parameter int unsigned DATA_W  = SIO_DATA_W,
    parameter int unsigned SHORT_W = SIO_SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              txb_we,
    input  logic [DATA_W-1:0] txb_wdata,
    input  logic              rxb_re,
    output logic [DATA_W-1:0] rxb_rdata,
    output logic              ser_txd,
    input  logic              ser_rxd,
    input  logic              txs_in,
    output logic              txs_out,
    output logic              txs_oe,
    input  logic              rxs_in,
    output logic              irq_tx,
    output logic              irq_rx
);
    sio_ctrl_t ctrl;
    logic      tx_full;
    logic      rx_full;

    sio_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata[6:0]),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    sio_tx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.tx_en),
        .int_syn   (ctrl.int_syn),
        .intv      (ctrl.intv),
        .long_w    (ctrl.long_w),
        .buf_we    (txb_we),
        .buf_wdata (txb_wdata),
        .sync_in   (txs_in),
        .sync_out  (txs_out),
        .txd       (ser_txd),
        .buf_full  (tx_full)
    );

    sio_rx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.rx_en),
        .intv      (ctrl.intv),
        .long_w    (ctrl.long_w),
        .sync_in   (rxs_in),
        .rxd       (ser_rxd),
        .buf_re    (rxb_re),
        .buf_rdata (rxb_rdata),
        .buf_full  (rx_full)
    );

    assign txs_oe = ctrl.int_syn;
    assign irq_tx = ctrl.tx_ie && ctrl.tx_en && !tx_full;
    assign irq_rx = ctrl.rx_ie && ctrl.rx_en && rx_full;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] reg_rdata,
    input logic        txs_out,
    input logic        txs_oe,
    input logic        irq_tx,
    input logic        irq_rx,
    input logic        ser_txd
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:7] == 9'd0); // R2

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] != 2'b00) |=> (reg_rdata[6:4] == $past(reg_rdata[6:4]))); // R3

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        txs_out |=> !txs_out); // R6

    AST_SYNC_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        txs_out |-> txs_oe); // R6

    AST_TX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (reg_rdata[3] && reg_rdata[1])); // R10

    AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (reg_rdata[2] && reg_rdata[0])); // R9

    AST_TXD_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[1] && !$past(reg_rdata[1])) |-> !ser_txd); // R11
endmodule

bind sio_port sio_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .txs_out   (txs_out),
    .txs_oe    (txs_oe),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .ser_txd   (ser_txd)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        txb_we = 1'b0;
    logic [15:0] txb_wdata = '0;
    logic        rxb_re = 1'b0;
    logic [15:0] rxb_rdata;
    logic        ser_txd, ser_rxd;
    logic        txs_in, txs_out, txs_oe, rxs_in;
    logic        irq_tx, irq_rx;
    logic        strb = 1'b0;
    logic        loop_txd = 1'b1;
    logic        use_int = 1'b0;
    logic        bench_rxd = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign ser_rxd = loop_txd ? ser_txd : bench_rxd;
    assign txs_in  = strb;
    assign rxs_in  = use_int ? txs_out : strb;

    sio_port u_sio_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .txb_we(txb_we), .txb_wdata(txb_wdata),
        .rxb_re(rxb_re), .rxb_rdata(rxb_rdata), .ser_txd(ser_txd),
        .ser_rxd(ser_rxd), .txs_in(txs_in), .txs_out(txs_out),
        .txs_oe(txs_oe), .rxs_in(rxs_in), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // {long, tx word, expected word}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 16'h00A5, 16'h00A5},
        {1'b0, 16'h3C81, 16'h0081},
        {1'b0, 16'hFFFF, 16'h00FF},
        {1'b1, 16'hBEEF, 16'hBEEF},
        {1'b1, 16'h0001, 16'h0001},
        {1'b1, 16'h8000, 16'h8000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        reg_we = 1'b1; reg_wdata = v; nx(); reg_we = 1'b0;
    endtask

    task automatic wr_tx(input logic [15:0] v);
        txb_we = 1'b1; txb_wdata = v; nx(); txb_we = 1'b0;
    endtask

    task automatic pulse_sync();
        strb = 1'b1; nx(); strb = 1'b0;
    endtask

    task automatic rd_rx();
        rxb_re = 1'b1; nx(); rxb_re = 1'b0;
    endtask

    task automatic get_tx(input int n, output logic [15:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w = {w[14:0], ser_txd};
            nx();
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [15:0] b;
        nx(); nx();
        // R1 reset state
        check("R1 ctrl", 32'(reg_rdata), 32'h0);
        check("R1 irq", {30'd0, irq_tx, irq_rx}, 32'h0);
        check("R1 txd/oe", {30'd0, ser_txd, txs_oe}, 32'h0);
        rst_n = 1'b1;
        nx();

        // table walk, interval mode, external sync, loopback (R4 R5 R9)
        for (int v = 0; v < 6; v++) begin
            int wl;
            wl = VEC[v][32] ? 16 : 8;
            wr_ctrl(16'h0000);
            wr_ctrl({10'd0, 1'b1, VEC[v][32], 4'b0111});
            wr_tx(VEC[v][31:16]);
            pulse_sync();
            get_tx(wl, w);
            check("R4 R5 tx word", 32'(w), 32'(VEC[v][15:0]));
            check("R9 R5 rx word", 32'(rxb_rdata), 32'(VEC[v][15:0]));
            check("R9 irq_rx set", 32'(irq_rx), 32'h1);
            rd_rx();
            check("R9 irq_rx clr", 32'(irq_rx), 32'h0);
        end

        // R2 reserved bits, R3 mode lock
        wr_ctrl(16'h0000);
        wr_ctrl(16'hFFFF);
        check("R2 reserved", 32'(reg_rdata), 32'h007F);
        wr_ctrl(16'h0003);
        check("R3 locked write", 32'(reg_rdata), 32'h0073);
        wr_ctrl(16'h0000);
        check("R3 still locked", 32'(reg_rdata), 32'h0070);
        wr_ctrl(16'h0000);
        check("R3 unlocked", 32'(reg_rdata), 32'h0000);

        // R10 transmit interrupt
        wr_ctrl(16'h000A);
        check("R10 empty", 32'(irq_tx), 32'h1);
        wr_tx(16'h0055);
        check("R10 full", 32'(irq_tx), 32'h0);
        wr_ctrl(16'h0000);

        // R7 continuous, 8-bit, external sync
        wr_ctrl(16'h0003);
        wr_tx(16'h00C3);
        pulse_sync();
        b = {15'd0, ser_txd};
        wr_tx(16'h005A);
        get_tx(7, w);
        w = {b[0], w[6:0]} & 16'h00FF;
        check("R7 first word", 32'(w), 32'h00C3);
        check("R7 rx first", 32'(rxb_rdata), 32'h00C3);
        get_tx(8, w);
        check("R7 second word", 32'(w), 32'h005A);
        check("R7 rx second", 32'(rxb_rdata), 32'h005A);
        wr_ctrl(16'h0000);

        // R8 interval, second word waits for its strobe
        wr_ctrl(16'h0020);
        wr_ctrl(16'h002B);
        wr_tx(16'h0011);
        pulse_sync();
        b = {15'd0, ser_txd};
        wr_tx(16'h0096);
        get_tx(7, w);
        check("R8 first word", 32'({b[0], w[6:0]}), 32'h0011);
        get_tx(10, w);
        check("R8 no strobe no data", 32'(w), 32'h0);
        check("R8 word held", 32'(irq_tx), 32'h0);
        check("R8 rx unchanged", 32'(rxb_rdata), 32'h0011);
        pulse_sync();
        get_tx(8, w);
        check("R8 second word", 32'(w), 32'h0096);
        wr_ctrl(16'h0000);

        // R6 internal sync generation, 16-bit
        wr_ctrl(16'h0050);
        wr_ctrl(16'h0053);
        use_int = 1'b1;
        check("R6 oe", 32'(txs_oe), 32'h1);
        check("R6 no pulse empty", 32'(txs_out), 32'h0);
        wr_tx(16'hA1B2);
        check("R6 pulse", 32'(txs_out), 32'h1);
        nx();
        check("R6 pulse width", 32'(txs_out), 32'h0);
        get_tx(16, w);
        check("R6 word", 32'(w), 32'hA1B2);
        check("R6 rx word", 32'(rxb_rdata), 32'hA1B2);
        use_int = 1'b0;
        wr_ctrl(16'h0000);

        // R11 disable mid-word, fresh sync needed
        wr_ctrl(16'h0003);
        wr_tx(16'h00FF);
        pulse_sync();
        get_tx(3, w);
        wr_ctrl(16'h0000);
        wr_ctrl(16'h0003);
        wr_tx(16'h00E7);
        get_tx(12, w);
        check("R11 idle after re-enable", 32'(w), 32'h0);
        pulse_sync();
        get_tx(8, w);
        check("R11 word after sync", 32'(w), 32'h00E7);
        check("R11 rx after sync", 32'(rxb_rdata), 32'h00E7);
        wr_ctrl(16'h0000);

        // R12 receive ignores the transmit-sync source select
        loop_txd = 1'b0;
        wr_ctrl(16'h0040);
        wr_ctrl(16'h0045);
        b = 16'h006D;
        strb = 1'b1;
        nx();
        strb = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bench_rxd = b[i];
            nx();
        end
        check("R12 rx word", 32'(rxb_rdata), 32'h006D);
        check("R12 rx irq", 32'(irq_rx), 32'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule